// File: doc/BRIEF.md
# Line-Granular Instruction Fetch Sequencer

This block steps an instruction address through memory one cache line at a time. Each cycle it offers its current fetch address to an external instruction cache as a probe. On a hit it presents the whole line downstream as a bundle. The bundle carries the starting address, the line data, the pipeline generation number supplied from outside, and a flag that marks the first bundle after a redirect. On a miss it asks memory for the line and keeps at most one such request in flight. The fill answer is written into the cache outside this block, and the next probe of that address then hits.

The address is split into a 3-bit field selector above a 12-bit offset. Moving to the next line aligns the offset down to a line boundary and adds one line. The carry wraps inside the offset and never reaches the selector. A redirect replaces the address in the cycle it arrives. In that same cycle it also drops any fill in flight and discards whatever line the old address would have produced.

Top module: `lfetch_seq`

## Requirements
- R1: While reset is asserted and just after it is released, `probe_pc` equals the `RESET_PC` parameter (default 0), no fill is in flight, and the first bundle is flagged as following a restart.
- R2: `bnd_valid` is high exactly when the probe of the current address hits, whatever the value of `bnd_ready`. A bundle transfers when `bnd_valid` and `bnd_ready` are both high. While a bundle is held back, the address does not change.
- R3: After a transfer with no redirect, the new address keeps the upper 3 selector bits. Its lower 12 bits are the old offset with its low log2(LINE_WORDS) bits cleared, plus LINE_WORDS, taken modulo 4096. For example 0x7FFC goes to 0x7000 and 0x2006 goes to 0x2008.
- R4: `fill_valid` is high only when the current probe misses and no fill is in flight. `fill_line_addr` equals `probe_pc` shifted right by log2(LINE_WORDS).
- R5: Once a fill is accepted (`fill_valid` and `fill_ready` both high), `fill_valid` stays low until a bundle transfers or a redirect arrives. A fill that is not accepted stays requested in the next cycle.
- R6: In a cycle with `redirect_valid` high, `probe_pc` equals `redirect_pc`. The line at the old address is not presented. Any fill in flight is forgotten, so a miss at the new address raises `fill_valid` in that same cycle.
- R7: `bnd_after_restart` is high for every bundle presented from the redirect cycle (or reset) up to and including the first transfer, and low after that.
- R8: A bundle carries `bnd_pc` equal to `probe_pc`, `bnd_line` equal to `probe_line` (word i in bits i*WORD_W upward), and `bnd_gen` equal to `gen_in` in the cycle of the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| redirect_valid | input | 1 | Load a new fetch address this cycle |
| redirect_pc | input | 15 | New fetch address |
| gen_in | input | GEN_W | Current pipeline generation number |
| probe_pc | output | 15 | Address presented to the cache probe |
| probe_hit | input | 1 | Cache holds the line of `probe_pc` |
| probe_line | input | LINE_WORDS*WORD_W | Line data on a hit |
| fill_valid | output | 1 | Line fill request |
| fill_ready | input | 1 | Memory accepts the fill request |
| fill_line_addr | output | 15-log2(LINE_WORDS) | Line number to fill |
| bnd_valid | output | 1 | Bundle available |
| bnd_ready | input | 1 | Downstream accepts the bundle |
| bnd_pc | output | 15 | Starting address of the bundle |
| bnd_line | output | LINE_WORDS*WORD_W | Line data of the bundle |
| bnd_gen | output | GEN_W | Generation tag of the bundle |
| bnd_after_restart | output | 1 | Bundle is the first after a redirect or reset |

## Verification
A redirect can land in the same cycle as a cache hit that would emit a line. It can also land while a fill is already in flight. The bench sets up the first case by making the old line resident and raising `bnd_ready` in the redirect cycle. It then judges that no bundle appears for the old address and that the address that follows is the redirect target, not the next line. For the second case it redirects while a fill is pending to a line that misses. It expects `fill_valid` to rise in that same cycle, with the new line number.

// File: rtl/lfetch_pkg.sv
package lfetch_pkg;
  localparam int DEF_FIELD_W    = 3;
  localparam int DEF_OFF_W      = 12;
  localparam int DEF_LINE_WORDS = 4;
  localparam int DEF_WORD_W     = 12;
  localparam int DEF_GEN_W      = 3;
endpackage

// File: rtl/lfetch_next_line.sv
module lfetch_next_line #(
  parameter int FIELD_W    = lfetch_pkg::DEF_FIELD_W,
  parameter int OFF_W      = lfetch_pkg::DEF_OFF_W,
  parameter int LINE_WORDS = lfetch_pkg::DEF_LINE_WORDS
) (
  input  logic [FIELD_W+OFF_W-1:0] cur_pc,
  output logic [FIELD_W+OFF_W-1:0] nxt_pc
);
  localparam int PC_W    = FIELD_W + OFF_W;
  localparam int LINE_LG = $clog2(LINE_WORDS);

  logic [OFF_W-1:0] off_base;
  logic [OFF_W-1:0] off_next;

  generate
    if (LINE_LG > 0) begin : g_align
      assign off_base = {cur_pc[OFF_W-1:LINE_LG], {LINE_LG{1'b0}}};
    end else begin : g_noalign
      assign off_base = cur_pc[OFF_W-1:0];
    end
  endgenerate

  // carry out of the offset is dropped: the selector field never moves
  assign off_next = off_base + OFF_W'(LINE_WORDS);
  assign nxt_pc   = {cur_pc[PC_W-1:OFF_W], off_next};
endmodule

// File: rtl/lfetch_fill_ctl.sv
module lfetch_fill_ctl #(
  parameter int PC_W    = 15,
  parameter int LINE_LG = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    probe_hit,
  input  logic                    take_bundle,
  input  logic [PC_W-1:0]         eff_pc,
  input  logic                    fill_ready,
  output logic                    fill_valid,
  output logic [PC_W-LINE_LG-1:0] fill_line_addr
);
  logic pend_q, pend_d, eff_pend, fill_fire;

  // a redirect forgets the request in flight in the same cycle
  assign eff_pend       = pend_q & ~restart;
  assign fill_valid     = ~eff_pend & ~probe_hit;
  assign fill_fire      = fill_valid & fill_ready;
  assign fill_line_addr = eff_pc[PC_W-1:LINE_LG];

  always_comb begin
    pend_d = eff_pend;
    if (take_bundle) pend_d = 1'b0;
    if (fill_fire)   pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end
endmodule

// File: rtl/lfetch_seq.sv
module lfetch_seq #(
  parameter int FIELD_W    = lfetch_pkg::DEF_FIELD_W,
  parameter int OFF_W      = lfetch_pkg::DEF_OFF_W,
  parameter int LINE_WORDS = lfetch_pkg::DEF_LINE_WORDS,
  parameter int WORD_W     = lfetch_pkg::DEF_WORD_W,
  parameter int GEN_W      = lfetch_pkg::DEF_GEN_W,
  parameter logic [FIELD_W+OFF_W-1:0] RESET_PC = '0
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          redirect_valid,
  input  logic [FIELD_W+OFF_W-1:0]                      redirect_pc,
  input  logic [GEN_W-1:0]                              gen_in,
  output logic [FIELD_W+OFF_W-1:0]                      probe_pc,
  input  logic                                          probe_hit,
  input  logic [LINE_WORDS*WORD_W-1:0]                  probe_line,
  output logic                                          fill_valid,
  input  logic                                          fill_ready,
  output logic [FIELD_W+OFF_W-$clog2(LINE_WORDS)-1:0]   fill_line_addr,
  output logic                                          bnd_valid,
  input  logic                                          bnd_ready,
  output logic [FIELD_W+OFF_W-1:0]                      bnd_pc,
  output logic [LINE_WORDS*WORD_W-1:0]                  bnd_line,
  output logic [GEN_W-1:0]                              bnd_gen,
  output logic                                          bnd_after_restart
);
  localparam int PC_W    = FIELD_W + OFF_W;
  localparam int LINE_LG = $clog2(LINE_WORDS);

  logic [PC_W-1:0] pc_q, pc_d, eff_pc, nxt_pc;
  logic            pc_en;
  logic            after_q, after_d, after_en, eff_after;
  logic            take_bundle;

  // redirect acts in the cycle it arrives
  assign eff_pc      = redirect_valid ? redirect_pc : pc_q;
  assign eff_after   = redirect_valid | after_q;
  assign take_bundle = probe_hit & bnd_ready;

  lfetch_next_line #(
    .FIELD_W(FIELD_W), .OFF_W(OFF_W), .LINE_WORDS(LINE_WORDS)
  ) u_next (
    .cur_pc(eff_pc),
    .nxt_pc(nxt_pc)
  );

  lfetch_fill_ctl #(
    .PC_W(PC_W), .LINE_LG(LINE_LG)
  ) u_fill (
    .clk(clk),
    .rst_n(rst_n),
    .restart(redirect_valid),
    .probe_hit(probe_hit),
    .take_bundle(take_bundle),
    .eff_pc(eff_pc),
    .fill_ready(fill_ready),
    .fill_valid(fill_valid),
    .fill_line_addr(fill_line_addr)
  );

  // next-state logic
  always_comb begin
    pc_en    = take_bundle | redirect_valid;
    pc_d     = take_bundle ? nxt_pc : redirect_pc;
    after_en = take_bundle | redirect_valid;
    after_d  = ~take_bundle;
  end

  // state registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= RESET_PC;
      after_q <= 1'b1;
    end else begin
      if (pc_en)    pc_q    <= pc_d;
      if (after_en) after_q <= after_d;
    end
  end

  assign probe_pc          = eff_pc;
  assign bnd_valid         = probe_hit;
  assign bnd_pc            = eff_pc;
  assign bnd_line          = probe_line;
  assign bnd_gen           = gen_in;
  assign bnd_after_restart = eff_after;
endmodule

// File: rtl/lfetch_seq_chk.sv
module lfetch_seq_chk #(
  parameter int FIELD_W    = 3,
  parameter int OFF_W      = 12,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 12,
  parameter int GEN_W      = 3
) (
  input logic                                        clk,
  input logic                                        rst_n,
  input logic                                        redirect_valid,
  input logic [FIELD_W+OFF_W-1:0]                    redirect_pc,
  input logic [GEN_W-1:0]                            gen_in,
  input logic [FIELD_W+OFF_W-1:0]                    probe_pc,
  input logic                                        probe_hit,
  input logic [LINE_WORDS*WORD_W-1:0]                probe_line,
  input logic                                        fill_valid,
  input logic                                        fill_ready,
  input logic [FIELD_W+OFF_W-$clog2(LINE_WORDS)-1:0] fill_line_addr,
  input logic                                        bnd_valid,
  input logic                                        bnd_ready,
  input logic [FIELD_W+OFF_W-1:0]                    bnd_pc,
  input logic [LINE_WORDS*WORD_W-1:0]                bnd_line,
  input logic [GEN_W-1:0]                            bnd_gen,
  input logic                                        bnd_after_restart
);
  localparam int PC_W = FIELD_W + OFF_W;

  logic alive_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alive_q <= 1'b0;
    else        alive_q <= 1'b1;
  end

  a_r6_redirect_now: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> probe_pc == redirect_pc);

  a_r7_flag_on_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && bnd_valid) |-> bnd_after_restart);

  a_r3_field_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && $past(bnd_valid && bnd_ready) && !redirect_valid)
      |-> probe_pc[PC_W-1:OFF_W] == $past(probe_pc[PC_W-1:OFF_W]));

  a_r5_one_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && $past(fill_valid && fill_ready) && !redirect_valid) |-> !fill_valid);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (alive_q && $past(bnd_valid && !bnd_ready) && !redirect_valid)
      |-> probe_pc == $past(probe_pc));
endmodule

bind lfetch_seq lfetch_seq_chk #(
  .FIELD_W(FIELD_W), .OFF_W(OFF_W), .LINE_WORDS(LINE_WORDS),
  .WORD_W(WORD_W), .GEN_W(GEN_W)
) u_chk (.*);

// File: tb/lfetch_seq_tb.sv
module lfetch_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 15;
  localparam int LA_W = 13;
  localparam int NRES = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             redirect_valid;
  logic [PC_W-1:0]  redirect_pc;
  logic [2:0]       gen_in;
  logic [PC_W-1:0]  probe_pc;
  logic             probe_hit;
  logic [47:0]      probe_line;
  logic             fill_valid, fill_ready;
  logic [LA_W-1:0]  fill_line_addr;
  logic             bnd_valid, bnd_ready;
  logic [PC_W-1:0]  bnd_pc;
  logic [47:0]      bnd_line;
  logic [2:0]       bnd_gen;
  logic             bnd_after_restart;

  int n_checks = 0;
  int n_fail   = 0;

  logic [LA_W-1:0] res_a [NRES];
  logic            res_v [NRES];

  always #(CLK_PERIOD/2) clk = ~clk;

  lfetch_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .gen_in(gen_in),
    .probe_pc(probe_pc), .probe_hit(probe_hit), .probe_line(probe_line),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_line_addr(fill_line_addr),
    .bnd_valid(bnd_valid), .bnd_ready(bnd_ready), .bnd_pc(bnd_pc),
    .bnd_line(bnd_line), .bnd_gen(bnd_gen), .bnd_after_restart(bnd_after_restart)
  );

  function automatic logic [11:0] word_of(input logic [LA_W-1:0] la, input int i);
    logic [PC_W-1:0] t;
    t = {la, 2'b00} + PC_W'(i);
    return t[11:0] ^ 12'hA5A;
  endfunction

  function automatic logic [47:0] line_of(input logic [LA_W-1:0] la);
    logic [47:0] l;
    for (int i = 0; i < 4; i++) l[i*12 +: 12] = word_of(la, i);
    return l;
  endfunction

  // line-store model: hit when the probed line is resident
  always_comb begin
    probe_hit = 1'b0;
    for (int k = 0; k < NRES; k++)
      if (res_v[k] && res_a[k] == probe_pc[PC_W-1:2]) probe_hit = 1'b1;
    probe_line = line_of(probe_pc[PC_W-1:2]);
  end

  task automatic clear_lines();
    for (int k = 0; k < NRES; k++) begin res_v[k] = 1'b0; res_a[k] = '0; end
  endtask

  task automatic add_line(input int slot, input logic [LA_W-1:0] la);
    res_a[slot] = la; res_v[slot] = 1'b1;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; redirect_valid = 1'b0; redirect_pc = '0; gen_in = 3'd2;
    fill_ready = 1'b0; bnd_ready = 1'b0; clear_lines();
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "probe_pc in reset", 64'(probe_pc), 64'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "probe_pc after reset", 64'(probe_pc), 64'h0);
    chk("R4", "fill_valid on miss", 64'(fill_valid), 64'h1);
    chk("R4", "fill_line_addr", 64'(fill_line_addr), 64'h0);
    chk("R2", "bnd_valid on miss", 64'(bnd_valid), 64'h0);
  endtask

  task automatic t_fill_once();
    tick(); #1;
    chk("R5", "unaccepted fill held", 64'(fill_valid), 64'h1);
    fill_ready = 1'b1; #1;
    tick(); #1;
    chk("R5", "no second fill", 64'(fill_valid), 64'h0);
    tick(); #1;
    chk("R5", "still one fill", 64'(fill_valid), 64'h0);
  endtask

  task automatic t_hit_emit();
    add_line(0, 13'h0); bnd_ready = 1'b1; #1;
    chk("R2", "bnd_valid on hit", 64'(bnd_valid), 64'h1);
    chk("R8", "bnd_pc", 64'(bnd_pc), 64'h0);
    chk("R8", "bnd_line", 64'(bnd_line), 64'(line_of(13'h0)));
    chk("R8", "bnd_gen", 64'(bnd_gen), 64'h2);
    chk("R1", "first bundle flagged", 64'(bnd_after_restart), 64'h1);
    tick(); #1;
    chk("R3", "next line", 64'(probe_pc), 64'h4);
    chk("R5", "fill after transfer", 64'(fill_valid), 64'h1);
  endtask

  task automatic t_stall();
    tick();
    add_line(1, 13'h1); bnd_ready = 1'b0; #1;
    chk("R2", "valid without ready", 64'(bnd_valid), 64'h1);
    tick(); #1;
    chk("R2", "pc held in stall", 64'(probe_pc), 64'h4);
    chk("R7", "flag low after transfer", 64'(bnd_after_restart), 64'h0);
    gen_in = 3'd5; bnd_ready = 1'b1; #1;
    chk("R8", "gen at transfer", 64'(bnd_gen), 64'h5);
    tick(); #1;
    chk("R3", "advance after stall", 64'(probe_pc), 64'h8);
  endtask

  task automatic t_wrap();
    clear_lines(); add_line(0, 13'h1FFF);
    redirect_valid = 1'b1; redirect_pc = 15'h7FFC; bnd_ready = 1'b1; #1;
    chk("R6", "redirect same cycle", 64'(probe_pc), 64'h7FFC);
    chk("R7", "flag on redirect bundle", 64'(bnd_after_restart), 64'h1);
    chk("R2", "hit at redirect target", 64'(bnd_valid), 64'h1);
    tick(); redirect_valid = 1'b0; #1;
    chk("R3", "offset wraps, field kept", 64'(probe_pc), 64'h7000);
    add_line(1, 13'h0801);
    redirect_valid = 1'b1; redirect_pc = 15'h2006; #1;
    tick(); redirect_valid = 1'b0; #1;
    chk("R3", "mid-line aligns", 64'(probe_pc), 64'h2008);
  endtask

  task automatic t_restart_cancels();
    clear_lines(); fill_ready = 1'b1; #1;
    chk("R4", "miss fills", 64'(fill_valid), 64'h1);
    tick(); #1;
    chk("R5", "fill pending", 64'(fill_valid), 64'h0);
    redirect_valid = 1'b1; redirect_pc = 15'h0100; #1;
    chk("R6", "fill reissued at redirect", 64'(fill_valid), 64'h1);
    chk("R6", "new fill line", 64'(fill_line_addr), 64'h40);
    tick(); redirect_valid = 1'b0; #1;
  endtask

  task automatic t_restart_vs_hit();
    add_line(0, 13'h40); bnd_ready = 1'b1;
    redirect_valid = 1'b1; redirect_pc = 15'h0200; #1;
    chk("R6", "old line not shown", 64'(bnd_valid), 64'h0);
    tick(); redirect_valid = 1'b0; #1;
    chk("R6", "redirect wins over hit", 64'(probe_pc), 64'h200);
    add_line(1, 13'h80); add_line(2, 13'h81); #1;
    chk("R7", "first after redirect", 64'(bnd_after_restart), 64'h1);
    tick(); #1;
    chk("R7", "second after redirect", 64'(bnd_after_restart), 64'h0);
    chk("R8", "bnd_pc second", 64'(bnd_pc), 64'h204);
  endtask

  initial begin
    t_reset();
    t_fill_once();
    t_hit_emit();
    t_stall();
    t_wrap();
    t_restart_cancels();
    t_restart_vs_hit();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule